// File: doc/BRIEF.md
# PLL Lock Status and Interrupt Register

This block is a single memory-mapped control and status register for a phase-locked loop. Software uses it to switch the PLL on and off and to choose which lock events raise an interrupt. The block watches the PLL's lock indicator after resynchronising it. It records every gain of lock and every loss of lock in a sticky flag, and it drives an interrupt line while an enabled flag is pending.

Reading the register returns the flags and clears them. A clock-source select input, taken from the clock multiplexer's setting, protects the PLL. While that select names the PLL as the system clock, a write cannot turn the PLL off. The other fields of the same write still apply.

Top module: `pll_lock_irq_regs`

## Requirements
- R1: After reset, `pll_en` and `irq` are 0 and a read of the register returns 0x00.
- R2: A write to address `REG_ADDR` loads bit 0 (PLL enable, driven on `pll_en`), bit 1 (unlock interrupt enable) and bit 2 (lock interrupt enable). A write to any other address changes nothing.
- R3: When the synchronised lock signal falls, bit 3 (unlock flag) is set. The flag is visible three rising edges after `lock_in` changes, and it holds until a read of `REG_ADDR`.
- R4: When the synchronised lock signal rises, bit 4 (lock flag) is set, with the same latency as R3. The flag holds until a read of `REG_ADDR`.
- R5: A read of `REG_ADDR` returns the flags as they stand in that cycle and clears bits 3 and 4 at the following edge. A read of any other address clears nothing.
- R6: If a lock event is detected in the same cycle as a clearing read, the corresponding flag is set after that edge.
- R7: `irq` is a register. It equals (bit 3 AND bit 1) OR (bit 4 AND bit 2), taken from the register state one cycle earlier.
- R8: While `clk_sel` equals 2'b01, a write with bit 0 = 0 leaves the PLL enable unchanged and still updates bits 1 and 2. A write with bit 0 = 1 enables the PLL whatever the value of `clk_sel`.
- R9: Bits 3 and 4 cannot be written, and bits 7 to 5 always read 0.
- R10: `bus_rdata` is 0 in every cycle without a read of `REG_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flags) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational during a read |
| lock_in | input | 1 | Lock indicator from the PLL, asynchronous |
| clk_sel | input | SEL_W | Current clock-source select |
| pll_en | output | 1 | PLL enable |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions can fall in the same cycle: the edge detector can set a flag in the cycle where a read clears it. The bench provokes this by changing `lock_in` and then issuing a read exactly two cycles later, when the detected edge meets the read strobe. The read must return the old value, and the next read must show the flag set. A behavioural model in the bench steps on every clock and checks `pll_en`, `irq` and `bus_rdata` against the model in every cycle. Directed checks cover the protected-enable writes and the masked interrupt.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    // Field positions inside the register; software decodes these
    localparam int BIT_EN     = 0;
    localparam int BIT_IE_UNL = 1;
    localparam int BIT_IE_LK  = 2;
    localparam int BIT_UNL    = 3;
    localparam int BIT_LK     = 4;
    localparam int USED_BITS  = 5;

    typedef struct packed {
        logic en;
        logic ie_unl;
        logic ie_lk;
        logic unl_flag;
        logic lk_flag;
        logic irq;
    } pll_regs_t;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pll_lock_edge.sv
module pll_lock_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/pll_lock_irq_regs.sv
module pll_lock_irq_regs
    import pll_lock_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter int                DATA_W      = 8,
    parameter int                SEL_W       = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] REG_ADDR    = '0,
    parameter logic [SEL_W-1:0]  SEL_PLL     = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lock_in,
    input  logic [SEL_W-1:0]  clk_sel,
    output logic              pll_en,
    output logic              irq
);
    pll_regs_t r_d, r_q;

    logic lock_sync, lock_rise, lock_fall;
    logic addr_hit, rd_hit, wr_hit, pll_is_clock;
    logic st_en, st_ie_unl, st_ie_lk, st_unl, st_lk;

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lock_in),
        .sync_out (lock_sync)
    );

    pll_lock_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lock_sync),
        .rise  (lock_rise),
        .fall  (lock_fall)
    );

    assign st_en     = r_q.en;
    assign st_ie_unl = r_q.ie_unl;
    assign st_ie_lk  = r_q.ie_lk;
    assign st_unl    = r_q.unl_flag;
    assign st_lk     = r_q.lk_flag;

    always_comb begin
        addr_hit     = (bus_addr == REG_ADDR);
        rd_hit       = bus_rd && addr_hit;
        wr_hit       = bus_wr && addr_hit;
        pll_is_clock = (clk_sel == SEL_PLL);

        r_d = r_q;
        // interrupt registered from the present state
        r_d.irq      = (r_q.unl_flag & r_q.ie_unl) | (r_q.lk_flag & r_q.ie_lk);
        // a new event wins over a clearing read
        r_d.unl_flag = (r_q.unl_flag & ~rd_hit) | lock_fall;
        r_d.lk_flag  = (r_q.lk_flag  & ~rd_hit) | lock_rise;

        if (wr_hit) begin
            r_d.ie_unl = bus_wdata[BIT_IE_UNL];
            r_d.ie_lk  = bus_wdata[BIT_IE_LK];
            if (bus_wdata[BIT_EN] || !pll_is_clock) begin
                r_d.en = bus_wdata[BIT_EN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata[BIT_EN]     = st_en;
            bus_rdata[BIT_IE_UNL] = st_ie_unl;
            bus_rdata[BIT_IE_LK]  = st_ie_lk;
            bus_rdata[BIT_UNL]    = st_unl;
            bus_rdata[BIT_LK]     = st_lk;
        end
    end

    assign pll_en = r_q.en;
    assign irq    = r_q.irq;
endmodule

// File: rtl/pll_lock_irq_chk.sv
module pll_lock_irq_chk #(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 8,
    parameter int                SEL_W    = 2,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter logic [SEL_W-1:0]  SEL_PLL  = 2'b01
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              wdata_en,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SEL_W-1:0]  clk_sel,
    input logic              pll_en,
    input logic              irq,
    input logic              ie_unl,
    input logic              ie_lk,
    input logic              unl_flag,
    input logic              lk_flag
);
    logic hit;
    assign hit = (bus_addr == REG_ADDR);

    // R9
    rdata_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:5] == '0);

    // R10
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && hit) |-> bus_rdata == '0);

    // R8
    pll_keep_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && clk_sel == SEL_PLL && !wdata_en && pll_en) |=> pll_en);

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past((unl_flag & ie_unl) | (lk_flag & ie_lk)));

    // R3
    unl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_flag && !(bus_rd && hit)) |=> unl_flag);

    // R4
    lk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_flag && !(bus_rd && hit)) |=> lk_flag);
endmodule

bind pll_lock_irq_regs pll_lock_irq_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W),
    .REG_ADDR (REG_ADDR),
    .SEL_PLL  (SEL_PLL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wdata_en  (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .clk_sel   (clk_sel),
    .pll_en    (pll_en),
    .irq       (irq),
    .ie_unl    (st_ie_unl),
    .ie_lk     (st_ie_lk),
    .unl_flag  (st_unl),
    .lk_flag   (st_lk)
);

// File: tb/pll_lock_irq_regs_tb.sv
`timescale 1ns/1ps
module pll_lock_irq_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       lock_in = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       pll_en, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_lock_irq_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_in(lock_in), .clk_sel(clk_sel), .pll_en(pll_en), .irq(irq)
    );

    // behavioural reference model
    bit m_en, m_ieu, m_iel, m_unl, m_lk, m_irq, m_prev;
    bit hist[$] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ieu = 0; m_iel = 0; m_unl = 0; m_lk = 0;
            m_irq = 0; m_prev = 0; hist = '{1'b0, 1'b0};
        end else begin
            bit cur, up, down, rclr, nirq;
            cur   = hist[0];
            up    = cur && !m_prev;
            down  = !cur && m_prev;
            rclr  = bus_rd && (bus_addr == 4'h0);
            nirq  = (m_unl && m_ieu) || (m_lk && m_iel);
            m_unl = (m_unl && !rclr) || down;
            m_lk  = (m_lk && !rclr) || up;
            if (bus_wr && bus_addr == 4'h0) begin
                m_ieu = bus_wdata[1];
                m_iel = bus_wdata[2];
                if (!(clk_sel == 2'b01 && !bus_wdata[0])) m_en = bus_wdata[0];
            end
            m_irq  = nirq;
            m_prev = cur;
            void'(hist.pop_front());
            hist.push_back(lock_in);
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [7:0] m_rd;
            m_rd = 8'h00;
            if (bus_rd && bus_addr == 4'h0)
                m_rd = {3'b000, m_lk, m_unl, m_iel, m_ieu, m_en};
            check({7'd0, pll_en}, {7'd0, m_en}, "R2/R8 model pll_en");
            check({7'd0, irq}, {7'd0, m_irq}, "R7 model irq");
            check(bus_rdata, m_rd, "R5/R10 model rdata");
        end
    end

    task automatic cyc(input logic rd, input logic wr, input logic [3:0] a, input logic [7:0] wd);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 8'h00);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        cyc(1'b1, 1'b0, a, 8'h00);
        check(bus_rdata, exp, tag);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check({7'd0, pll_en}, 8'h00, "R1 pll_en after reset");
        check({7'd0, irq}, 8'h00, "R1 irq after reset");
        rd_chk(4'h0, 8'h00, "R1 read after reset");

        // R2 / R10 / R9
        cyc(1'b0, 1'b1, 4'h0, 8'h07);
        idle(1);
        check(bus_rdata, 8'h00, "R10 rdata without read");
        rd_chk(4'h3, 8'h00, "R10 read other address");
        rd_chk(4'h0, 8'h07, "R2 write readback");
        check({7'd0, pll_en}, 8'h01, "R2 pll_en driven");
        cyc(1'b0, 1'b1, 4'h0, 8'hFF);
        rd_chk(4'h0, 8'h07, "R9 read-only and top bits");
        cyc(1'b0, 1'b1, 4'h5, 8'h00);
        rd_chk(4'h0, 8'h07, "R2 other address write ignored");

        // R4 lock gained, R7 interrupt, R5 clear
        idle(1); lock_in = 1'b1;
        idle(4);
        check({7'd0, irq}, 8'h01, "R7 irq on lock flag");
        rd_chk(4'h0, 8'h17, "R4 lock flag set");
        rd_chk(4'h0, 8'h07, "R5 flag cleared by read");
        idle(1);
        check({7'd0, irq}, 8'h00, "R7 irq drops after clear");

        // R3 lock lost, R5 other address does not clear
        idle(1); lock_in = 1'b0;
        idle(4);
        rd_chk(4'h3, 8'h00, "R5 other address read");
        rd_chk(4'h0, 8'h0F, "R3 unlock flag set");
        rd_chk(4'h0, 8'h07, "R5 unlock flag cleared");

        // R6 event in the same cycle as the clearing read
        idle(1); lock_in = 1'b1;
        idle(1);
        rd_chk(4'h0, 8'h07, "R6 read in event cycle");
        rd_chk(4'h0, 8'h17, "R6 flag kept after collision");
        rd_chk(4'h0, 8'h07, "R6 flag cleared afterwards");

        // R7 masking
        cyc(1'b0, 1'b1, 4'h0, 8'h03);
        idle(1); lock_in = 1'b0;
        idle(5);
        check({7'd0, irq}, 8'h01, "R7 irq on unlock flag");
        cyc(1'b0, 1'b1, 4'h0, 8'h01);
        idle(2);
        check({7'd0, irq}, 8'h00, "R7 irq masked");
        rd_chk(4'h0, 8'h09, "R3 flag held while masked");

        // R8 protected enable
        clk_sel = 2'b01;
        cyc(1'b0, 1'b1, 4'h0, 8'h06);
        rd_chk(4'h0, 8'h07, "R8 disable blocked, enables applied");
        check({7'd0, pll_en}, 8'h01, "R8 pll_en held");
        cyc(1'b0, 1'b1, 4'h0, 8'h02);
        rd_chk(4'h0, 8'h03, "R8 lock enable cleared, pll kept");
        clk_sel = 2'b10;
        cyc(1'b0, 1'b1, 4'h0, 8'h00);
        idle(1);
        check({7'd0, pll_en}, 8'h00, "R8 disable allowed off PLL clock");
        rd_chk(4'h0, 8'h00, "R8 readback after disable");
        clk_sel = 2'b01;
        cyc(1'b0, 1'b1, 4'h0, 8'h01);
        rd_chk(4'h0, 8'h01, "R8 enable allowed on PLL clock");

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule